// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block holds the sixteen 32-bit logical registers of a small processor that runs in several privilege modes. Some logical registers have one physical copy per mode, so the storage location a logical index refers to depends on the mode. The active mode is held in the low five bits of a current status word kept inside the block. Indices 0 to 7 and 15 have a single copy. In fast-interrupt mode, indices 8 to 12 use a private set. Indices 13 and 14 have one copy for each of six banks.

Two combinational read ports and one synchronous write port translate logical indices using the current mode. A user-bank flag sends those ports to the User copies instead, which a privileged handler uses to save or restore the User context. While the flag is set, a separate base port still reads and writes back the base register in the current mode's bank. A side port reads or writes the stack or link copy of any named mode without changing mode. Each exception mode has one saved status word. A write to index 15 that is marked as an exception return copies the current mode's saved status into the current status.

Top module: `banked_regfile`

## Requirements
- R1: On synchronous reset the current status becomes 0x00000013 (Supervisor), every saved status reads 0, every register reads 0 and all error outputs are 0.
- R2: Indices 0-7 and 15 have one physical copy. A value written in any mode reads back unchanged in every other mode.
- R3: In FIQ mode (mode 0x11), indices 8-12 use a private copy. All other modes share the User copy of indices 8-12.
- R4: Indices 13 and 14 have six copies: one shared by User (0x10) and System (0x1F), and one each for FIQ 0x11, IRQ 0x12, Supervisor 0x13, Abort 0x17 and Undefined 0x1B.
- R5: Any other value in status bits [4:0] drives err_mode high while it is held, and the registers are then mapped as in User mode.
- R6: While user_bank is 1, both read ports and the write port use the User copies whatever the current mode is.
- R7: The base port (base_idx/base_data) always uses the current mode's copy, even while user_bank is 1.
- R8: A writeback request (wb_en) while user_bank is 1 sets err_wb for the next cycle and leaves the base register unchanged. Without user_bank, the writeback writes base_idx in the current bank.
- R9: The side port selects a mode (bk_mode) and index 14 (bk_sel=1) or 13 (bk_sel=0). It reads that copy combinationally and writes it on the clock edge, and the current status is not changed. For an illegal bk_mode the read returns 0 and the write is dropped.
- R10: A write to index 15 with set_flags=1 or user_bank=1 is an exception return. On the same edge, index 15 takes wr_data and the current status takes the current mode's saved status. This has priority over cpsr_we.
- R11: An exception return in User, System or an illegal mode sets err_ret for the next cycle and leaves the current status unchanged. In those modes spsr reads 0 and spsr_we is ignored.
- R12: When a write in the current cycle targets the physical register that a read port addresses, that read port shows the new value in the same cycle.
- R13: When several writes hit one physical register on the same edge, the write port wins over the writeback, and the writeback wins over the side port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_a_idx | input | 4 | Read port A logical index |
| rd_a_data | output | 32 | Read port A data (combinational) |
| rd_b_idx | input | 4 | Read port B logical index |
| rd_b_data | output | 32 | Read port B data (combinational) |
| user_bank | input | 1 | Send read/write ports to the User copies |
| set_flags | input | 1 | Flag-setting qualifier on the write port |
| wr_en | input | 1 | Write port enable |
| wr_idx | input | 4 | Write port logical index |
| wr_data | input | 32 | Write port data |
| base_idx | input | 4 | Base register index (current mode bank) |
| base_data | output | 32 | Base register value |
| wb_en | input | 1 | Base writeback request |
| wb_data | input | 32 | Base writeback data |
| bk_en | input | 1 | Side port enable |
| bk_we | input | 1 | Side port write |
| bk_mode | input | 5 | Side port mode encoding |
| bk_sel | input | 1 | Side port select: 0 index 13, 1 index 14 |
| bk_wdata | input | 32 | Side port write data |
| bk_rdata | output | 32 | Side port read data |
| cpsr_we | input | 1 | Current status write enable |
| cpsr_wdata | input | 32 | Current status write data |
| spsr_we | input | 1 | Saved status write enable (current mode) |
| spsr_wdata | input | 32 | Saved status write data |
| cpsr | output | 32 | Current status |
| spsr | output | 32 | Saved status of current mode, 0 if none |
| err_mode | output | 1 | Current mode encoding is illegal |
| err_wb | output | 1 | Writeback refused during user-bank access |
| err_ret | output | 1 | Exception return without a saved status |

## Verification
The bench follows single values through mode switches to show which copies are shared. A wrong bank map would make a FIQ write to index 8 visible in Supervisor, or keep User and System stack values apart. It sets user_bank together with the base port and a writeback in IRQ mode. A design that used the User bank for the base, or let the refused writeback through, would return the wrong base value. Exception return is tested both with a saved status and from User mode, where a faulty design would load a zero status. Same-cycle forwarding and write collisions are tested because a missing bypass or a reversed priority leaves a stale or lost value.

// File: rtl/banked_regfile_pkg.sv
package banked_regfile_pkg;
  typedef enum logic [2:0] {BK_USR, BK_FIQ, BK_IRQ, BK_SVC, BK_ABT, BK_UND} bank_e;

  localparam int NUM_BANKS  = 6;
  localparam int LOG_REGS   = 16;
  localparam int IDX_W      = $clog2(LOG_REGS);
  localparam int FIQ_FIRST  = 8;
  localparam int SP_IDX     = 13;
  localparam int LR_IDX     = 14;
  localparam int PC_IDX     = 15;
  localparam int FIQ_CNT    = SP_IDX - FIQ_FIRST;
  localparam int PHYS_FIQ   = SP_IDX;
  localparam int PHYS_SPLR  = PHYS_FIQ + FIQ_CNT;
  localparam int PHYS_PC    = PHYS_SPLR + 2 * NUM_BANKS;
  localparam int NUM_PHYS   = PHYS_PC + 1;
  localparam int PHYS_W     = $clog2(NUM_PHYS);

  localparam logic [4:0] M_USR = 5'h10;
  localparam logic [4:0] M_FIQ = 5'h11;
  localparam logic [4:0] M_IRQ = 5'h12;
  localparam logic [4:0] M_SVC = 5'h13;
  localparam logic [4:0] M_ABT = 5'h17;
  localparam logic [4:0] M_UND = 5'h1B;
  localparam logic [4:0] M_SYS = 5'h1F;
endpackage

// File: rtl/bank_mode_dec.sv
module bank_mode_dec
  import banked_regfile_pkg::*;
(
  input  logic [4:0] mode,
  output bank_e      bank,
  output logic       legal
);
  always_comb begin
    legal = 1'b1;
    unique case (mode)
      M_USR, M_SYS: bank = BK_USR;
      M_FIQ:        bank = BK_FIQ;
      M_IRQ:        bank = BK_IRQ;
      M_SVC:        bank = BK_SVC;
      M_ABT:        bank = BK_ABT;
      M_UND:        bank = BK_UND;
      default: begin
        bank  = BK_USR;
        legal = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/bank_index_map.sv
module bank_index_map
  import banked_regfile_pkg::*;
(
  input  logic [IDX_W-1:0]  idx,
  input  bank_e             bank,
  output logic [PHYS_W-1:0] phys
);
  always_comb begin
    if (idx == IDX_W'(PC_IDX))
      phys = PHYS_W'(PHYS_PC);
    else if (idx < IDX_W'(FIQ_FIRST))
      phys = PHYS_W'(idx);
    else if (idx < IDX_W'(SP_IDX))
      phys = (bank == BK_FIQ) ? PHYS_W'(PHYS_FIQ + int'(idx) - FIQ_FIRST) : PHYS_W'(idx);
    else
      phys = PHYS_W'(PHYS_SPLR + 2 * int'(bank) + int'(idx) - SP_IDX);
  end
endmodule

// File: rtl/bank_status.sv
module bank_status
  import banked_regfile_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  bank_e             cur_bank,
  input  logic              cur_legal,
  input  logic              cpsr_we,
  input  logic [DATA_W-1:0] cpsr_wdata,
  input  logic              spsr_we,
  input  logic [DATA_W-1:0] spsr_wdata,
  input  logic              ret_req,
  output logic [DATA_W-1:0] cpsr_q,
  output logic [DATA_W-1:0] spsr_cur,
  output logic              err_ret
);
  localparam logic [DATA_W-1:0] RESET_STATUS = DATA_W'(M_SVC);

  logic [DATA_W-1:0] saved_q [NUM_BANKS];
  logic              has_saved;

  assign has_saved = cur_legal && (cur_bank != BK_USR);
  assign spsr_cur  = has_saved ? saved_q[cur_bank] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      cpsr_q  <= RESET_STATUS;
      err_ret <= 1'b0;
      for (int b = 0; b < NUM_BANKS; b++) saved_q[b] <= '0;
    end else begin
      err_ret <= ret_req && !has_saved;
      if (ret_req) begin
        if (has_saved) cpsr_q <= saved_q[cur_bank];
      end else if (cpsr_we) begin
        cpsr_q <= cpsr_wdata;
      end
      if (spsr_we && has_saved) saved_q[cur_bank] <= spsr_wdata;
    end
  end

  assert_reset_svc_R1: assert property (@(posedge clk)
    $past(rst) |-> cpsr_q == RESET_STATUS);

  assert_ret_restores_R10: assert property (@(posedge clk) disable iff (rst)
    (ret_req && has_saved) |=> cpsr_q == $past(spsr_cur));

  assert_ret_refused_R11: assert property (@(posedge clk) disable iff (rst)
    (ret_req && !has_saved) |=> (err_ret && $stable(cpsr_q)));
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import banked_regfile_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        rd_a_idx,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [3:0]        rd_b_idx,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic              user_bank,
  input  logic              set_flags,
  input  logic              wr_en,
  input  logic [3:0]        wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [3:0]        base_idx,
  output logic [DATA_W-1:0] base_data,
  input  logic              wb_en,
  input  logic [DATA_W-1:0] wb_data,
  input  logic              bk_en,
  input  logic              bk_we,
  input  logic [4:0]        bk_mode,
  input  logic              bk_sel,
  input  logic [DATA_W-1:0] bk_wdata,
  output logic [DATA_W-1:0] bk_rdata,
  input  logic              cpsr_we,
  input  logic [DATA_W-1:0] cpsr_wdata,
  input  logic              spsr_we,
  input  logic [DATA_W-1:0] spsr_wdata,
  output logic [DATA_W-1:0] cpsr,
  output logic [DATA_W-1:0] spsr,
  output logic              err_mode,
  output logic              err_wb,
  output logic              err_ret
);
  // map slots: 0 read A, 1 read B, 2 base, 3 write, 4 side port
  localparam int NUM_MAP = 5;
  localparam int NUM_RD  = 4;

  bank_e cur_bank, bk_bank, port_bank;
  logic  cur_legal, bk_legal;

  bank_mode_dec u_cur_dec (.mode(cpsr[4:0]), .bank(cur_bank), .legal(cur_legal));
  bank_mode_dec u_bk_dec  (.mode(bk_mode),   .bank(bk_bank),  .legal(bk_legal));

  assign err_mode  = !cur_legal;
  assign port_bank = user_bank ? BK_USR : cur_bank;

  logic [IDX_W-1:0]  map_idx  [NUM_MAP];
  bank_e             map_bank [NUM_MAP];
  logic [PHYS_W-1:0] map_phys [NUM_MAP];

  assign map_idx[0]  = rd_a_idx;  assign map_bank[0] = port_bank;
  assign map_idx[1]  = rd_b_idx;  assign map_bank[1] = port_bank;
  assign map_idx[2]  = base_idx;  assign map_bank[2] = cur_bank;
  assign map_idx[3]  = wr_idx;    assign map_bank[3] = port_bank;
  assign map_idx[4]  = bk_sel ? IDX_W'(LR_IDX) : IDX_W'(SP_IDX);
  assign map_bank[4] = bk_bank;

  for (genvar m = 0; m < NUM_MAP; m++) begin : g_map
    bank_index_map u_map (.idx(map_idx[m]), .bank(map_bank[m]), .phys(map_phys[m]));
  end

  logic [PHYS_W-1:0] p_base, p_wr, p_bk;
  logic              wb_ok, bk_wr_ok, ret_req;

  assign p_base   = map_phys[2];
  assign p_wr     = map_phys[3];
  assign p_bk     = map_phys[4];
  assign wb_ok    = wb_en && !user_bank;
  assign bk_wr_ok = bk_en && bk_we && bk_legal;
  assign ret_req  = wr_en && (wr_idx == IDX_W'(PC_IDX)) && (set_flags || user_bank);

  logic [DATA_W-1:0] rf_q [NUM_PHYS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_PHYS; i++) rf_q[i] <= '0;
      err_wb <= 1'b0;
    end else begin
      err_wb <= wb_en && user_bank;
      if (bk_wr_ok) rf_q[p_bk]   <= bk_wdata;
      if (wb_ok)    rf_q[p_base] <= wb_data;
      if (wr_en)    rf_q[p_wr]   <= wr_data;
    end
  end

  logic [PHYS_W-1:0] rd_phys [NUM_RD];
  logic [DATA_W-1:0] rd_val  [NUM_RD];

  assign rd_phys[0] = map_phys[0];
  assign rd_phys[1] = map_phys[1];
  assign rd_phys[2] = map_phys[2];
  assign rd_phys[3] = map_phys[4];

  for (genvar r = 0; r < NUM_RD; r++) begin : g_rd
    always_comb begin
      rd_val[r] = rf_q[rd_phys[r]];
      if (bk_wr_ok && p_bk == rd_phys[r])   rd_val[r] = bk_wdata;
      if (wb_ok    && p_base == rd_phys[r]) rd_val[r] = wb_data;
      if (wr_en    && p_wr == rd_phys[r])   rd_val[r] = wr_data;
    end
  end

  assign rd_a_data = rd_val[0];
  assign rd_b_data = rd_val[1];
  assign base_data = rd_val[2];
  assign bk_rdata  = (bk_en && bk_legal) ? rd_val[3] : '0;

  bank_status #(.DATA_W(DATA_W)) u_status (
    .clk(clk), .rst(rst),
    .cur_bank(cur_bank), .cur_legal(cur_legal),
    .cpsr_we(cpsr_we), .cpsr_wdata(cpsr_wdata),
    .spsr_we(spsr_we), .spsr_wdata(spsr_wdata),
    .ret_req(ret_req),
    .cpsr_q(cpsr), .spsr_cur(spsr), .err_ret(err_ret)
  );

  assert_wb_flag_R8: assert property (@(posedge clk) disable iff (rst)
    (wb_en && user_bank) |=> err_wb);

  assert_wb_base_kept_R8: assert property (@(posedge clk) disable iff (rst)
    (wb_en && user_bank && !wr_en && !bk_wr_ok) |=> rf_q[$past(p_base)] == $past(rf_q[p_base]));

  assert_side_no_mode_R9: assert property (@(posedge clk) disable iff (rst)
    (bk_en && bk_we && !cpsr_we && !ret_req) |=> $stable(cpsr));

  assert_port_wins_R13: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wb_ok && p_wr == p_base) |=> rf_q[$past(p_wr)] == $past(wr_data));
endmodule

// File: tb/banked_regfile_tb_top.sv
module banked_regfile_tb_top;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [3:0] rd_a_idx, rd_b_idx, wr_idx, base_idx;
  logic [W-1:0] rd_a_data, rd_b_data, wr_data, base_data, wb_data, bk_wdata, bk_rdata;
  logic [W-1:0] cpsr_wdata, spsr_wdata, cpsr, spsr;
  logic user_bank, set_flags, wr_en, wb_en, bk_en, bk_we, bk_sel, cpsr_we, spsr_we;
  logic [4:0] bk_mode;
  logic err_mode, err_wb, err_ret;

  banked_regfile #(.DATA_W(W)) dut_i (
    .clk(clk), .rst(rst),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .user_bank(user_bank), .set_flags(set_flags),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .base_idx(base_idx), .base_data(base_data),
    .wb_en(wb_en), .wb_data(wb_data),
    .bk_en(bk_en), .bk_we(bk_we), .bk_mode(bk_mode), .bk_sel(bk_sel),
    .bk_wdata(bk_wdata), .bk_rdata(bk_rdata),
    .cpsr_we(cpsr_we), .cpsr_wdata(cpsr_wdata),
    .spsr_we(spsr_we), .spsr_wdata(spsr_wdata),
    .cpsr(cpsr), .spsr(spsr),
    .err_mode(err_mode), .err_wb(err_wb), .err_ret(err_ret)
  );

  // output selectors: 0 rd_a, 1 rd_b, 2 base, 3 side, 4 cpsr, 5 spsr, 6 {mode,ret,wb} errors
  typedef struct {
    string      req;
    int         sel;
    logic [W-1:0] exp;
  } sb_item_t;

  sb_item_t sb_q[$];
  event     cmp_ev;
  int       n_tests = 0;
  int       n_fail  = 0;
  bit       done    = 1'b0;

  function automatic logic [W-1:0] pick(int sel);
    case (sel)
      0: return rd_a_data;
      1: return rd_b_data;
      2: return base_data;
      3: return bk_rdata;
      4: return cpsr;
      5: return spsr;
      default: return {29'd0, err_mode, err_ret, err_wb};
    endcase
  endfunction

  initial forever begin
    @(cmp_ev);
    while (sb_q.size() > 0) begin
      sb_item_t it;
      logic [W-1:0] act;
      it  = sb_q.pop_front();
      act = pick(it.sel);
      n_tests++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s: actual %h expected %h", it.req, act, it.exp);
      end
    end
  end

  task automatic push(string req, int sel, logic [W-1:0] exp);
    sb_item_t it;
    it.req = req; it.sel = sel; it.exp = exp;
    sb_q.push_back(it);
    -> cmp_ev;
    #1;
  endtask

  task automatic idle();
    rd_a_idx = 0; rd_b_idx = 0; wr_idx = 0; base_idx = 0;
    wr_data = 0; wb_data = 0; bk_wdata = 0; cpsr_wdata = 0; spsr_wdata = 0;
    user_bank = 0; set_flags = 0; wr_en = 0; wb_en = 0; bk_en = 0; bk_we = 0;
    bk_sel = 0; bk_mode = 0; cpsr_we = 0; spsr_we = 0;
  endtask

  task automatic edge_done();
    @(posedge clk); #1; idle();
  endtask

  task automatic wr(logic [3:0] idx, logic [W-1:0] d, logic ub, logic sf);
    @(negedge clk); idle();
    wr_en = 1; wr_idx = idx; wr_data = d; user_bank = ub; set_flags = sf;
    edge_done();
  endtask

  task automatic set_mode(logic [4:0] m);
    @(negedge clk); idle();
    cpsr_we = 1; cpsr_wdata = {27'd0, m};
    edge_done();
  endtask

  task automatic chk_rd(string req, logic [3:0] idx, logic ub, logic [W-1:0] exp);
    @(negedge clk); idle();
    rd_a_idx = idx; user_bank = ub; #1;
    push(req, 0, exp);
  endtask

  task automatic chk_side(string req, logic [4:0] m, logic s, logic [W-1:0] exp);
    @(negedge clk); idle();
    bk_en = 1; bk_mode = m; bk_sel = s; #1;
    push(req, 3, exp);
  endtask

  initial begin
    idle();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1 reset state
    #1;
    push("R1 cpsr", 4, 32'h13);
    push("R1 spsr", 5, 0);
    push("R1 errors", 6, 0);
    chk_rd("R1 r0", 4'd0, 0, 0);
    chk_rd("R1 r13", 4'd13, 0, 0);

    // Supervisor writes
    wr(4'd0, 32'hA0A0_0001, 0, 0);
    wr(4'd13, 32'h5555_0013, 0, 0);
    wr(4'd8, 32'h0000_0808, 0, 0);
    wr(4'd15, 32'h0000_1000, 0, 0);

    // FIQ
    set_mode(5'h11);
    chk_rd("R2 r0 shared in FIQ", 4'd0, 0, 32'hA0A0_0001);
    chk_rd("R2 r15 shared in FIQ", 4'd15, 0, 32'h0000_1000);
    chk_rd("R3 FIQ r8 private", 4'd8, 0, 0);
    chk_rd("R4 FIQ r13 private", 4'd13, 0, 0);
    wr(4'd8, 32'hF800_0008, 0, 0);
    wr(4'd13, 32'hF130_0000, 0, 0);
    chk_rd("R3 FIQ r8 readback", 4'd8, 0, 32'hF800_0008);

    // System and User share
    set_mode(5'h1F);
    chk_rd("R3 SYS r8 user copy", 4'd8, 0, 32'h0000_0808);
    chk_rd("R4 SYS r13 fresh", 4'd13, 0, 0);
    wr(4'd13, 32'h1300_0010, 0, 0);
    set_mode(5'h10);
    chk_rd("R4 USR r13 shared with SYS", 4'd13, 0, 32'h1300_0010);

    // IRQ and side port
    set_mode(5'h12);
    chk_rd("R4 IRQ r13 private", 4'd13, 0, 0);
    chk_side("R9 side read SVC r13", 5'h13, 0, 32'h5555_0013);
    chk_side("R9 side read FIQ r13", 5'h11, 0, 32'hF130_0000);
    @(negedge clk); idle();
    bk_en = 1; bk_we = 1; bk_mode = 5'h17; bk_sel = 1; bk_wdata = 32'hAB14_0017;
    edge_done();
    push("R9 mode unchanged", 4, 32'h12);
    chk_side("R9 side read ABT r14", 5'h17, 1, 32'hAB14_0017);
    chk_side("R9 illegal side mode", 5'h05, 0, 0);

    // user-bank access from IRQ
    chk_rd("R6 user bank r13", 4'd13, 1, 32'h1300_0010);
    @(negedge clk); idle();
    base_idx = 13; user_bank = 1; #1;
    push("R7 base uses IRQ bank", 2, 0);
    wr(4'd13, 32'h1302_0010, 1, 0);
    chk_rd("R6 user write lands in User copy", 4'd13, 1, 32'h1302_0010);
    chk_rd("R6 IRQ r13 untouched", 4'd13, 0, 0);

    // writeback refusal
    @(negedge clk); idle();
    wb_en = 1; base_idx = 13; wb_data = 32'hDEAD_BEEF; user_bank = 1;
    edge_done();
    push("R8 err_wb raised", 6, 32'h1);
    chk_rd("R8 base unchanged", 4'd13, 0, 0);
    @(negedge clk); idle();
    wb_en = 1; base_idx = 13; wb_data = 32'h3333_0012;
    edge_done();
    push("R8 err_wb clear", 6, 0);
    chk_rd("R8 normal writeback", 4'd13, 0, 32'h3333_0012);

    // exception return from IRQ
    @(negedge clk); idle();
    spsr_we = 1; spsr_wdata = 32'h2000_0013;
    edge_done();
    push("R10 spsr written", 5, 32'h2000_0013);
    wr(4'd15, 32'h0000_2000, 0, 1);
    push("R10 cpsr restored", 4, 32'h2000_0013);
    chk_rd("R10 r15 written", 4'd15, 0, 32'h0000_2000);

    // exception return refused in User
    set_mode(5'h10);
    @(negedge clk); idle();
    spsr_we = 1; spsr_wdata = 32'h1234_5678;
    edge_done();
    push("R11 no spsr in USR", 5, 0);
    wr(4'd15, 32'h0000_3000, 0, 1);
    push("R11 err_ret raised", 6, 32'h2);
    push("R11 cpsr kept", 4, 32'h10);

    // illegal mode
    set_mode(5'h05);
    push("R5 err_mode raised", 6, 32'h4);
    chk_rd("R5 illegal maps to User", 4'd13, 0, 32'h1302_0010);
    set_mode(5'h13);
    push("R5 err_mode clear", 6, 0);

    // forwarding
    @(negedge clk); idle();
    wr_en = 1; wr_idx = 3; wr_data = 32'h0F0F_0003; rd_b_idx = 3; #1;
    push("R12 same-cycle forward", 1, 32'h0F0F_0003);
    edge_done();

    // priority
    @(negedge clk); idle();
    wr_en = 1; wr_idx = 4; wr_data = 32'h44; wb_en = 1; base_idx = 4; wb_data = 32'h55;
    edge_done();
    chk_rd("R13 write port beats writeback", 4'd4, 0, 32'h44);
    @(negedge clk); idle();
    bk_en = 1; bk_we = 1; bk_mode = 5'h13; bk_sel = 0; bk_wdata = 32'h66;
    wb_en = 1; base_idx = 13; wb_data = 32'h77;
    edge_done();
    chk_rd("R13 writeback beats side port", 4'd13, 0, 32'h77);

    wait (sb_q.size() == 0);
    #1;
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule